// File: doc/BRIEF.md
# ADC Command Frame Shifter

This block drives one full-duplex SPI transaction towards a multichannel delta-sigma converter. A host hands it one command (opcode, register address, register count, an optional 16-bit write value and a channel count). The block then lowers chip select and shifts out a frame of 24-bit words, most significant bit first. The command goes first. A write value follows only for register writes. Next comes a CRC-16 word over everything already sent, and zero words fill the rest of the frame.

While transmitting, the block samples the converter's output line on every falling SCLK edge. It stores the incoming frame in a flat byte buffer, which the host reads once the frame has finished. The block only places and collects bits. It does not interpret the received contents, and it does not chain frames into longer sequences.

The command input is a valid/ready port. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that edge until the frame is complete. While `cmd_ready` is low, `cmd_valid` is ignored and no command is queued, so the host has to hold or re-present its request. The command fields are sampled only on the accepting edge.

Top module: `adc_cmd_framer`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0, `cmd_ready` is 1, `frame_done` is 0 and `rx_bytes` is all zero.
- R2: Chip select stays low for exactly (N+2)*24 SCLK periods, where N is the channel count taken from `cmd_nch`.
- R3: SPI mode 1. SCLK is low whenever chip select is high. Every SCLK phase, including the low phase before the first rising edge, lasts `SCLK_HALF` system clocks. MOSI changes only together with a rising SCLK edge.
- R4: The 16-bit command word depends on `cmd_op`: 0 sends 0x0000, 1 sends 0x0011, 2 sends 0xA000 | addr<<7 | count and 3 sends 0x6000 | addr<<7 | count. addr is 5 bits and count is 7 bits, holding the number of registers minus one.
- R5: Each 16-bit value fills the upper two bytes of its 24-bit word, and the low byte is sent as zero.
- R6: For opcodes 0 to 2, word 1 carries a CRC-16 over the 3 bytes of word 0. The CRC uses polynomial 0x1021, starts at 0xFFFF, runs MSB first and is not reflected.
- R7: For opcode 3, word 1 carries `cmd_data` and word 2 carries the same CRC computed over the 6 bytes of words 0 and 1.
- R8: Every word after the CRC word is transmitted as all zeros.
- R9: MISO is sampled on each falling SCLK edge. Received frame byte k lands in `rx_bytes[8k+7:8k]`, and its first received bit goes to bit 7. Bytes beyond the frame read as zero.
- R10: `cmd_ready` is high only while idle, and `cmd_valid` has no effect while it is low. `frame_done` is a one-cycle pulse on the cycle chip select returns high. `rx_bytes` holds its value from then until the next accepted command.
- R11: A `cmd_nch` value below `MIN_CH` is treated as `MIN_CH`, and a value above `MAX_CH` is treated as `MAX_CH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_op | input | 2 | Opcode: 0 null, 1 reset, 2 register read, 3 register write |
| cmd_addr | input | 5 | Register address |
| cmd_count | input | 7 | Register count minus one |
| cmd_data | input | 16 | Write value (opcode 3 only) |
| cmd_nch | input | 4 | Channel count of the converter |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| frame_done | output | 1 | Frame-complete pulse |
| rx_bytes | output | 240 | Received frame, byte k at bits 8k+7:8k |

## Verification
The embedded properties assume that reset is applied before the first command. They also assume that `cmd_nch` is wide enough to express `MAX_CH`. The received-data properties further assume that MISO is stable across each falling SCLK edge. The stimulus keeps to this in two ways: it changes MISO only on the falling system-clock edge that follows a detected SCLK rise, and it presents commands on falling system-clock edges. It also deliberately asserts `cmd_valid` while a frame is in flight, and it drives channel counts outside the legal range to exercise the clamp.

// File: rtl/adc_frm_pkg.sv
package adc_frm_pkg;
  localparam int unsigned WORD_BITS = 24;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RST = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } frm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } frm_state_e;

  function automatic logic [15:0] cmd_encode(frm_op_e op, logic [4:0] addr, logic [6:0] cnt);
    case (op)
      OP_NOP:  return 16'h0000;
      OP_RST:  return 16'h0011;
      OP_RD:   return 16'hA000 | {4'b0000, addr, cnt};
      default: return 16'h6000 | {4'b0000, addr, cnt};
    endcase
  endfunction

  function automatic logic [15:0] crc_step(logic [15:0] crc, logic b);
    return {crc[14:0], 1'b0} ^ (((crc[15] ^ b) == 1'b1) ? CRC_POLY : 16'h0000);
  endfunction
endpackage

// File: rtl/adc_frm_sclk.sv
module adc_frm_sclk #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = en && (cnt == CW'(HALF - 1));
  assign rise = wrap && !sclk;
  assign fall = wrap && sclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sclk);

  // R3
  sclk_edge_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> $stable(sclk));
endmodule

// File: rtl/adc_frm_crc.sv
module adc_frm_crc
  import adc_frm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        step,
  input  logic        din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n)     crc <= CRC_SEED;
    else if (init)  crc <= CRC_SEED;
    else if (step)  crc <= crc_step(crc, din);
  end

  // R6
  crc_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (crc == 16'hFFFF));

  // R6
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !step) |=> $stable(crc));
endmodule

// File: rtl/adc_frm_rx.sv
module adc_frm_rx #(
  parameter int unsigned BITS = 240,
  localparam int unsigned PW = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            sample,
  input  logic [PW-1:0]   pos,
  input  logic            din,
  output logic [BITS-1:0] data
);
  logic [PW-1:0] idx;

  // byte stays pos/8, bit inside the byte mirrors so the first bit is bit 7
  assign idx = {pos[PW-1:3], ~pos[2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n)      data <= '0;
    else if (clear)  data <= '0;
    else if (sample) data[idx] <= din;
  end

  // R9
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (data == '0));

  // R10
  rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !sample) |=> $stable(data));
endmodule

// File: rtl/adc_cmd_framer.sv
module adc_cmd_framer
  import adc_frm_pkg::*;
#(
  parameter int unsigned SCLK_HALF = 2,
  parameter int unsigned MAX_CH    = 8,
  parameter int unsigned MIN_CH    = 2,
  parameter int unsigned NCH_W     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_op,
  input  logic [4:0]  cmd_addr,
  input  logic [6:0]  cmd_count,
  input  logic [15:0] cmd_data,
  input  logic [NCH_W-1:0] cmd_nch,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        frame_done,
  output logic [(MAX_CH+2)*WORD_BITS-1:0] rx_bytes
);
  localparam int unsigned WORDS_MAX = MAX_CH + 2;
  localparam int unsigned RX_BITS   = WORDS_MAX * WORD_BITS;
  localparam int unsigned PW        = $clog2(RX_BITS);
  localparam int unsigned WW        = $clog2(WORDS_MAX);
  localparam int unsigned BW        = $clog2(WORD_BITS);

  frm_state_e    st_q;
  frm_op_e       op_q;
  logic [15:0]   cmd_q;
  logic [15:0]   data_q;
  logic [PW-1:0] last_q;
  logic [WW-1:0] crc_word_q;
  logic [PW-1:0] pos_q;
  logic [WW-1:0] wrd_q;
  logic [BW-1:0] bit_q;
  logic          cs_n_q;
  logic          mosi_q;
  logic          done_q;

  logic          accept;
  logic          run;
  logic          rise;
  logic          fall;
  logic [15:0]   crc;
  logic [15:0]   word_val;
  logic          tx_bit;
  logic          crc_step_en;
  int unsigned   n_req;
  int unsigned   n_eff;
  logic [PW-1:0] last_calc;

  assign cmd_ready  = (st_q == ST_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign run        = (st_q == ST_RUN);
  assign spi_cs_n   = cs_n_q;
  assign spi_mosi   = mosi_q;
  assign frame_done = done_q;

  // channel count clamp and last bit index of the frame
  always_comb begin
    n_req = 32'(cmd_nch);
    n_eff = n_req;
    if (n_req < MIN_CH)      n_eff = MIN_CH;
    else if (n_req > MAX_CH) n_eff = MAX_CH;
    last_calc = PW'((n_eff + 2) * WORD_BITS - 1);
  end

  // outgoing word content and the bit at the current position
  always_comb begin
    word_val = 16'h0000;
    if (wrd_q == '0)                              word_val = cmd_q;
    else if (wrd_q == crc_word_q)                 word_val = crc;
    else if (op_q == OP_WR && wrd_q == WW'(1))    word_val = data_q;
    tx_bit = (bit_q < BW'(16)) ? word_val[4'd15 - bit_q[3:0]] : 1'b0;
  end

  assign crc_step_en = run && rise && (wrd_q < crc_word_q);

  adc_frm_sclk #(.HALF(SCLK_HALF)) u_sclk (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (run),
    .sclk (spi_sclk),
    .rise (rise),
    .fall (fall)
  );

  adc_frm_crc u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .init (accept),
    .step (crc_step_en),
    .din  (tx_bit),
    .crc  (crc)
  );

  adc_frm_rx #(.BITS(RX_BITS)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .sample(run && fall),
    .pos   (pos_q),
    .din   (spi_miso),
    .data  (rx_bytes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      op_q       <= OP_NOP;
      cmd_q      <= '0;
      data_q     <= '0;
      last_q     <= '0;
      crc_word_q <= WW'(1);
      pos_q      <= '0;
      wrd_q      <= '0;
      bit_q      <= '0;
      cs_n_q     <= 1'b1;
      mosi_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q       <= frm_op_e'(cmd_op);
            cmd_q      <= cmd_encode(frm_op_e'(cmd_op), cmd_addr, cmd_count);
            data_q     <= cmd_data;
            last_q     <= last_calc;
            crc_word_q <= (frm_op_e'(cmd_op) == OP_WR) ? WW'(2) : WW'(1);
            pos_q      <= '0;
            wrd_q      <= '0;
            bit_q      <= '0;
            cs_n_q     <= 1'b0;
            st_q       <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (rise) mosi_q <= tx_bit;
          if (fall) begin
            if (pos_q == last_q) begin
              st_q <= ST_FIN;
            end else begin
              pos_q <= pos_q + 1'b1;
              if (bit_q == BW'(WORD_BITS - 1)) begin
                bit_q <= '0;
                wrd_q <= wrd_q + 1'b1;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end
        end
        ST_FIN: begin
          cs_n_q <= 1'b1;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid) |=> $stable(rx_bytes));

  // R3
  cs_idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R3
  mosi_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_mosi) |-> $rose(spi_sclk));

  // R8
  zero_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rise && (wrd_q > crc_word_q)) |=> !spi_mosi);

  // R2
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pos_q <= last_q));
endmodule

// File: tb/tb_adc_cmd_framer.sv
module tb_adc_cmd_framer;
  localparam int HALF = 2;
  localparam int MAXC = 8;
  localparam int RXB  = (MAXC + 2) * 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic           cmd_valid = 1'b0;
  logic           cmd_ready;
  logic [1:0]     cmd_op = '0;
  logic [4:0]     cmd_addr = '0;
  logic [6:0]     cmd_count = '0;
  logic [15:0]    cmd_data = '0;
  logic [3:0]     cmd_nch = 4'd2;
  logic           spi_sclk, spi_cs_n, spi_mosi;
  logic           spi_miso = 1'b0;
  logic           frame_done;
  logic [RXB-1:0] rx_bytes;

  adc_cmd_framer #(.SCLK_HALF(HALF), .MAX_CH(MAXC), .MIN_CH(2), .NCH_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_count(cmd_count), .cmd_data(cmd_data),
    .cmd_nch(cmd_nch), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .frame_done(frame_done), .rx_bytes(rx_bytes)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int             nbits;
    logic [RXB-1:0] tx;
    logic [RXB-1:0] rx;
  } exp_t;

  exp_t q[$];
  int   miso_seed = 0;
  int   frames_seen = 0;
  logic [RXB-1:0] last_rx_exp = '0;

  task automatic chk(input bit ok, input string req, input logic [RXB-1:0] act, input logic [RXB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int seed, int k);
    return 8'((seed * 7 + k * 29 + 3) & 255);
  endfunction

  function automatic logic [15:0] tb_crc(logic [RXB-1:0] v, int nbytes);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int k = 0; k < nbytes; k++) begin
      for (int i = 7; i >= 0; i--) begin
        logic b;
        b = v[8*k + i];
        c = ((c[15] ^ b) == 1'b1) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
      end
    end
    return c;
  endfunction

  function automatic logic [15:0] tb_cmd(int op, int addr, int cnt);
    case (op)
      0: return 16'h0000;
      1: return 16'h0011;
      2: return 16'hA000 | 16'(addr * 128) | 16'(cnt);
      default: return 16'h6000 | 16'(addr * 128) | 16'(cnt);
    endcase
  endfunction

  // driver: builds the expected frame, queues it, then presents the command
  task automatic send(input int op, input int addr, input int cnt, input int data,
                      input int nch, input int seed, input bit poke_busy);
    exp_t e;
    int n, nbytes, target;
    logic [15:0] c, crc;
    n = (nch < 2) ? 2 : ((nch > MAXC) ? MAXC : nch);
    nbytes = 3 * (n + 2);
    e.nbits = nbytes * 8;
    e.tx = '0;
    e.rx = '0;
    c = tb_cmd(op, addr, cnt);
    e.tx[7:0]  = c[15:8];
    e.tx[15:8] = c[7:0];
    if (op == 3) begin
      e.tx[31:24] = 8'(data >> 8);
      e.tx[39:32] = 8'(data);
      crc = tb_crc(e.tx, 6);
      e.tx[55:48] = crc[15:8];
      e.tx[63:56] = crc[7:0];
    end else begin
      crc = tb_crc(e.tx, 3);
      e.tx[31:24] = crc[15:8];
      e.tx[39:32] = crc[7:0];
    end
    for (int k = 0; k < nbytes; k++) e.rx[8*k +: 8] = pat(seed, k);
    q.push_back(e);
    miso_seed = seed;
    target = frames_seen + 1;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_addr  = 5'(addr);
    cmd_count = 7'(cnt);
    cmd_data  = 16'(data);
    cmd_nch   = 4'(nch);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke_busy) begin
      // R10: a different command offered while busy must be ignored
      repeat (3) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op = 2'd1;
      cmd_nch = 4'd8;
      repeat (20) @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (frames_seen < target) @(negedge clk);
    repeat (6) @(negedge clk);
    // R10: received bytes held after completion
    chk(rx_bytes == last_rx_exp, "R10 rx hold", rx_bytes, last_rx_exp);
  endtask

  // monitor: slave model plus comparison at chip-select release
  logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0;
  bit in_frame = 1'b0;
  int nb = 0, since_edge = 0, bad_timing = 0, bad_launch = 0, idle_sclk = 0;
  logic [RXB-1:0] got = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !spi_cs_n) begin
        in_frame = 1'b1; nb = 0; got = '0; since_edge = 0; bad_timing = 0; bad_launch = 0;
      end else if (in_frame && !spi_cs_n) begin
        since_edge++;
        if (spi_sclk != prev_sclk) begin
          if (since_edge != HALF) bad_timing++;
          since_edge = 0;
        end
        if (spi_mosi != prev_mosi && !(spi_sclk && !prev_sclk)) bad_launch++;
        if (spi_sclk && !prev_sclk) begin
          logic [7:0] pb;
          pb = pat(miso_seed, nb / 8);
          spi_miso = pb[7 - (nb % 8)];
        end
        if (!spi_sclk && prev_sclk) begin
          if (nb < RXB) got[(nb / 8) * 8 + 7 - (nb % 8)] = spi_mosi;
          nb++;
        end
      end else if (!in_frame && spi_sclk) begin
        idle_sclk++;
      end
      if (!prev_cs && spi_cs_n && in_frame) begin
        in_frame = 1'b0;
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected frame", RXB'(nb), '0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(nb == e.nbits, "R2/R11 frame length", RXB'(nb), RXB'(e.nbits));
          chk(got == e.tx, "R4/R5/R6/R7/R8 mosi frame", got, e.tx);
          chk(frame_done == 1'b1, "R10 done pulse", RXB'(frame_done), RXB'(1));
          chk(rx_bytes == e.rx, "R9 rx capture", rx_bytes, e.rx);
          chk(bad_timing == 0 && bad_launch == 0, "R3 sclk timing and mosi launch",
              RXB'(bad_timing + bad_launch), '0);
          last_rx_exp = e.rx;
        end
        frames_seen++;
      end
    end
    prev_sclk = spi_sclk;
    prev_cs   = spi_cs_n;
    prev_mosi = spi_mosi;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && spi_mosi == 1'b0, "R1 spi idle",
        RXB'({spi_cs_n, spi_sclk, spi_mosi}), RXB'(3'b100));
    chk(cmd_ready == 1'b1 && frame_done == 1'b0, "R1 handshake idle",
        RXB'({cmd_ready, frame_done}), RXB'(2'b10));
    chk(rx_bytes == '0, "R1 rx cleared", rx_bytes, '0);

    send(0, 0, 0, 0, 2, 1, 1'b0);           // R4 null
    send(1, 0, 0, 0, 4, 2, 1'b0);           // R4 reset
    send(2, 3, 0, 0, 8, 3, 1'b1);           // R4/R6 read, busy poke R10
    send(3, 2, 0, 16'h1234, 3, 4, 1'b0);    // R7 write
    send(3, 31, 127, 16'hFFFF, 0, 5, 1'b0); // R11 low clamp
    send(2, 17, 5, 0, 15, 6, 1'b0);         // R11 high clamp

    repeat (60) @(negedge clk);
    // R10: no extra frame from the ignored request
    chk(frames_seen == 6 && q.size() == 0 && spi_cs_n == 1'b1, "R10 ignored while busy",
        RXB'(frames_seen), RXB'(6));
    // R3: sclk never toggled while chip select was high
    chk(idle_sclk == 0, "R3 sclk low while deselected", RXB'(idle_sclk), '0);
    finish_run();
  end
endmodule